// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a memory-mapped watchdog timer. Software reaches it through two register frames. Each frame has its own chip select. One frame holds only the refresh (kick) register. The other frame holds the enable and status word, the period, and the absolute deadline. A free-running system count enters on a port. The block compares that count against a stored deadline. When software enables the timer, the deadline is set to the count plus the programmed period.

If software lets a full period pass without a kick, the block raises a warning output and moves the deadline on by one more period. If that second period also passes without a kick, the block raises a reset-request output. The system reset generator is expected to act on that request. Any write to the refresh register clears both outputs and restarts the period, whatever data is written. Any write to the enable/status word does the same. Software may also write the deadline directly to set an absolute expiry time.

Both frames carry two read-only identification words at the top of the frame. All read data comes out of a single registered port. Interrupt routing, the reset generator and bus bridging sit outside this block.

Top module: `wdt_twostage`

## Requirements
- R1: After synchronous reset, every register reads zero: enable/status, period, both deadline words. The warning and reset-request outputs are low.
- R2: A write to refresh-frame offset 0x000, with any data, clears warning and reset-request on the next cycle. The same write loads the deadline with the sampled count plus the period. A full period without a kick then raises warning again.
- R3: A write to control-frame offset 0x000 does three things: it sets the enable from data bit 0, it refreshes exactly as in R2, and it ignores data bits 1 and 2. Reading that offset returns enable in bit 0, warning in bit 1, reset-request in bit 2 and zeros elsewhere.
- R4: While enabled, with warning low, warning rises on the first clock edge at which the sampled count is at or past the deadline. On that edge the deadline is reloaded with the count plus the period. With period P, warning rises P edges after the enabling write.
- R5: While enabled, with warning high, reset-request rises once the count reaches the deadline again. With period P, reset-request rises 2P edges after the last refresh. Reset-request is never high while warning is low.
- R6: While disabled, neither warning nor reset-request is raised, however long the count runs.
- R7: With period zero, an enabling write makes warning rise on the very next edge and reset-request on the edge after that.
- R8: Control-frame offset 0x008 is the read/write period register. Offsets 0x010 (low word) and 0x014 (high word) read back the current deadline. A write to either deadline word sets an absolute deadline without clearing the stage outputs.
- R9: In both frames, offset 0xFCC returns the interface identification word and offset 0xFD0 returns the part identification word. Writes to these offsets are ignored.
- R10: Read data and its valid strobe appear one cycle after a read is presented with a chip select. Unmapped offsets, and refresh-frame offset 0x000, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_count_i | input | CNT_W | Free-running system count |
| rf_sel_i | input | 1 | Refresh-frame chip select |
| cf_sel_i | input | 1 | Control-frame chip select (takes priority if both are high) |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte offset within the selected frame |
| wdata_i | input | BUS_W | Write data |
| rdata_o | output | BUS_W | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after the read |
| warn_o | output | 1 | First-stage timeout flag |
| reset_req_o | output | 1 | Second-stage timeout flag, reset request |

## Verification
A write takes effect on the clock edge that samples it, so flags and register contents are checked at the falling edge just after that edge. Read data is due exactly one cycle after the read strobe. The read task pushes each expected word into a queue, and a falling-edge monitor pops and compares it whenever valid is high. The bench keeps its own copy of the system count and records the value seen at each write edge. From that it computes each deadline, then counts edges so that it samples the warning output one edge before and on the edge P, and reset-request one edge before and on the edge 2P. The zero-period case and the direct-deadline case use the same edge counting.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Offsets within a frame; the refresh/control split is fixed by software
  localparam int OFS_CTRL    = 'h000;
  localparam int OFS_PERIOD  = 'h008;
  localparam int OFS_DLINE   = 'h010;
  localparam int OFS_IFACE   = 'hFCC;
  localparam int OFS_IDENT   = 'hFD0;
  localparam int OFS_REFRESH = 'h000;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_CTRL,
    RS_PERIOD,
    RS_DLINE,
    RS_IFACE,
    RS_IDENT
  } rd_sel_e;
endpackage

// File: rtl/wdt_frame_decode.sv
module wdt_frame_decode
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CMP_WORDS = 2,
  parameter int WIDX_W    = 1
) (
  input  logic                 rf_sel,
  input  logic                 cf_sel,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 refresh,
  output logic                 ctrl_wr,
  output logic                 period_wr,
  output logic [CMP_WORDS-1:0] dline_wr,
  output logic                 rd_req,
  output rd_sel_e              rd_sel,
  output logic [WIDX_W-1:0]    rd_word
);
  logic                 cf_act;
  logic                 rf_act;
  logic [CMP_WORDS-1:0] dline_hit;
  logic                 hit_ctrl;
  logic                 hit_period;
  logic                 hit_iface;
  logic                 hit_ident;

  assign cf_act = cf_sel;
  assign rf_act = rf_sel & ~cf_sel;

  assign hit_ctrl   = (addr == ADDR_W'(OFS_CTRL));
  assign hit_period = (addr == ADDR_W'(OFS_PERIOD));
  assign hit_iface  = (addr == ADDR_W'(OFS_IFACE));
  assign hit_ident  = (addr == ADDR_W'(OFS_IDENT));

  genvar gi;
  generate
    for (gi = 0; gi < CMP_WORDS; gi++) begin : g_dline_hit
      assign dline_hit[gi] = (addr == ADDR_W'(OFS_DLINE + 4 * gi));
    end
  endgenerate

  assign refresh   = rf_act & wr_en & (addr == ADDR_W'(OFS_REFRESH));
  assign ctrl_wr   = cf_act & wr_en & hit_ctrl;
  assign period_wr = cf_act & wr_en & hit_period;
  assign dline_wr  = {CMP_WORDS{cf_act & wr_en}} & dline_hit;
  assign rd_req    = rd_en & (rf_sel | cf_sel);

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < CMP_WORDS; i++) begin
      if (dline_hit[i]) rd_word = WIDX_W'(i);
    end
  end

  always_comb begin
    rd_sel = RS_NONE;
    if (cf_act) begin
      if (hit_ctrl)        rd_sel = RS_CTRL;
      else if (hit_period) rd_sel = RS_PERIOD;
      else if (|dline_hit) rd_sel = RS_DLINE;
      else if (hit_iface)  rd_sel = RS_IFACE;
      else if (hit_ident)  rd_sel = RS_IDENT;
    end else if (rf_act) begin
      if (hit_iface)       rd_sel = RS_IFACE;
      else if (hit_ident)  rd_sel = RS_IDENT;
    end
  end
endmodule

// File: rtl/wdt_stage_core.sv
module wdt_stage_core #(
  parameter int CNT_W     = 64,
  parameter int OFF_W     = 32,
  parameter int BUS_W     = 32,
  parameter int CMP_WORDS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CNT_W-1:0]     sys_count,
  input  logic                 refresh,
  input  logic                 ctrl_wr,
  input  logic                 period_wr,
  input  logic [CMP_WORDS-1:0] dline_wr,
  input  logic [BUS_W-1:0]     wdata,
  output logic                 en_o,
  output logic                 ws0_o,
  output logic                 ws1_o,
  output logic [OFF_W-1:0]     period_o,
  output logic [CNT_W-1:0]     dline_o
);
  localparam int PAD_W = CMP_WORDS * BUS_W;

  logic             en_q;
  logic             ws0_q;
  logic             ws1_q;
  logic [OFF_W-1:0] period_q;
  logic [CNT_W-1:0] dline_q;
  logic [PAD_W-1:0] dline_pad;
  logic [PAD_W-1:0] dline_merge;
  logic [CNT_W-1:0] next_dline;
  logic             reached;
  logic             kick;

  assign dline_pad  = PAD_W'(dline_q);
  assign next_dline = sys_count + CNT_W'(period_q);
  assign reached    = (sys_count >= dline_q);
  assign kick       = refresh | ctrl_wr;

  // Merge any written deadline word into the current deadline
  always_comb begin
    dline_merge = dline_pad;
    for (int i = 0; i < CMP_WORDS; i++) begin
      if (dline_wr[i]) dline_merge[i*BUS_W +: BUS_W] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      ws0_q    <= 1'b0;
      ws1_q    <= 1'b0;
      period_q <= '0;
      dline_q  <= '0;
    end else begin
      if (period_wr) period_q <= wdata[OFF_W-1:0];
      if (ctrl_wr)   en_q     <= wdata[0];
      if (kick) begin
        dline_q <= next_dline;
        ws0_q   <= 1'b0;
        ws1_q   <= 1'b0;
      end else if (|dline_wr) begin
        dline_q <= dline_merge[CNT_W-1:0];
      end else if (en_q && reached) begin
        if (!ws0_q) begin
          ws0_q   <= 1'b1;
          dline_q <= next_dline;
        end else begin
          ws1_q   <= 1'b1;
        end
      end
    end
  end

  assign en_o     = en_q;
  assign ws0_o    = ws0_q;
  assign ws1_o    = ws1_q;
  assign period_o = period_q;
  assign dline_o  = dline_q;
endmodule

// File: rtl/wdt_read_mux.sv
module wdt_read_mux
  import wdt_pkg::*;
#(
  parameter int             CNT_W     = 64,
  parameter int             OFF_W     = 32,
  parameter int             BUS_W     = 32,
  parameter int             CMP_WORDS = 2,
  parameter int             WIDX_W    = 1,
  parameter logic [BUS_W-1:0] IFACE_ID = '0,
  parameter logic [BUS_W-1:0] IDENT_ID = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  rd_sel_e           rd_sel,
  input  logic [WIDX_W-1:0] rd_word,
  input  logic              en,
  input  logic              ws0,
  input  logic              ws1,
  input  logic [OFF_W-1:0]  period,
  input  logic [CNT_W-1:0]  dline,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              rvalid_o
);
  localparam int PAD_W = CMP_WORDS * BUS_W;

  logic [PAD_W-1:0] dline_pad;
  logic [BUS_W-1:0] rd_val;
  logic [BUS_W-1:0] rdata_q;
  logic             rvalid_q;

  assign dline_pad = PAD_W'(dline);

  always_comb begin
    unique case (rd_sel)
      RS_CTRL:   rd_val = {{(BUS_W-3){1'b0}}, ws1, ws0, en};
      RS_PERIOD: rd_val = BUS_W'(period);
      RS_DLINE:  rd_val = dline_pad[rd_word*BUS_W +: BUS_W];
      RS_IFACE:  rd_val = IFACE_ID;
      RS_IDENT:  rd_val = IDENT_ID;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rd_val;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
  import wdt_pkg::*;
#(
  parameter int               CNT_W    = 64,
  parameter int               OFF_W    = 32,
  parameter int               BUS_W    = 32,
  parameter int               ADDR_W   = 12,
  parameter logic [BUS_W-1:0] IFACE_ID = 32'h0002_1A5D,
  parameter logic [BUS_W-1:0] IDENT_ID = 32'h0000_1F0A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  sys_count_i,
  input  logic              rf_sel_i,
  input  logic              cf_sel_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              rvalid_o,
  output logic              warn_o,
  output logic              reset_req_o
);
  localparam int CMP_WORDS = (CNT_W + BUS_W - 1) / BUS_W;
  localparam int WIDX_W    = (CMP_WORDS > 1) ? $clog2(CMP_WORDS) : 1;

  logic                 refresh;
  logic                 ctrl_wr;
  logic                 period_wr;
  logic [CMP_WORDS-1:0] dline_wr;
  logic                 rd_req;
  rd_sel_e              rd_sel;
  logic [WIDX_W-1:0]    rd_word;
  logic                 en_q;
  logic                 ws0;
  logic                 ws1;
  logic [OFF_W-1:0]     period;
  logic [CNT_W-1:0]     dline;

  wdt_frame_decode #(
    .ADDR_W(ADDR_W), .CMP_WORDS(CMP_WORDS), .WIDX_W(WIDX_W)
  ) u_decode (
    .rf_sel(rf_sel_i), .cf_sel(cf_sel_i), .wr_en(wr_en_i), .rd_en(rd_en_i),
    .addr(addr_i), .refresh(refresh), .ctrl_wr(ctrl_wr),
    .period_wr(period_wr), .dline_wr(dline_wr), .rd_req(rd_req),
    .rd_sel(rd_sel), .rd_word(rd_word)
  );

  wdt_stage_core #(
    .CNT_W(CNT_W), .OFF_W(OFF_W), .BUS_W(BUS_W), .CMP_WORDS(CMP_WORDS)
  ) u_core (
    .clk(clk), .rst(rst), .sys_count(sys_count_i), .refresh(refresh),
    .ctrl_wr(ctrl_wr), .period_wr(period_wr), .dline_wr(dline_wr),
    .wdata(wdata_i), .en_o(en_q), .ws0_o(ws0), .ws1_o(ws1),
    .period_o(period), .dline_o(dline)
  );

  wdt_read_mux #(
    .CNT_W(CNT_W), .OFF_W(OFF_W), .BUS_W(BUS_W), .CMP_WORDS(CMP_WORDS),
    .WIDX_W(WIDX_W), .IFACE_ID(IFACE_ID), .IDENT_ID(IDENT_ID)
  ) u_rdmux (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_sel(rd_sel),
    .rd_word(rd_word), .en(en_q), .ws0(ws0), .ws1(ws1),
    .period(period), .dline(dline), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  assign warn_o      = ws0;
  assign reset_req_o = ws1;
endmodule

// File: rtl/wdt_twostage_chk.sv
module wdt_twostage_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              rf_sel,
  input logic              cf_sel,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              rvalid,
  input logic              en,
  input logic              ws0,
  input logic              ws1
);
  AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rf_sel && !cf_sel && wr_en && addr == '0) |=> (!ws0 && !ws1)); // R2
  AST_CTRL_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cf_sel && wr_en && addr == '0) |=> (!ws0 && !ws1)); // R3
  AST_WARN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(ws0) |-> $past(en)); // R4
  AST_RESETREQ_AFTER_WARN: assert property (@(posedge clk) disable iff (rst)
    $rose(ws1) |-> $past(ws0)); // R5
  AST_RESETREQ_IMPLIES_WARN: assert property (@(posedge clk) disable iff (rst)
    ws1 |-> ws0); // R5
  AST_IDLE_STAYS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!en && !ws0) |=> !ws0); // R6
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rf_sel || cf_sel)) |=> rvalid); // R10
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && (rf_sel || cf_sel)) |=> !rvalid); // R10
endmodule

bind wdt_twostage wdt_twostage_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rf_sel(rf_sel_i), .cf_sel(cf_sel_i),
  .wr_en(wr_en_i), .rd_en(rd_en_i), .addr(addr_i), .rvalid(rvalid_o),
  .en(en_q), .ws0(warn_o), .ws1(reset_req_o)
);

// File: tb/wdt_twostage_tb.sv
module wdt_twostage_tb;
  localparam logic [31:0] IFACE = 32'h0002_1A5D;
  localparam logic [31:0] IDENT = 32'h0000_1F0A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] cnt;
  logic        rf_sel = 0, cf_sel = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, warn, rreq;

  int          checks = 0;
  int          fails  = 0;
  logic [63:0] last_cnt;
  logic [63:0] c0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 64'd1;
  end

  wdt_twostage u_dut (
    .clk(clk), .rst(rst), .sys_count_i(cnt), .rf_sel_i(rf_sel),
    .cf_sel_i(cf_sel), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .warn_o(warn), .reset_req_o(rreq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Tasks are entered at a falling edge and return at the next one
  task automatic wr(input bit ctrl, input logic [11:0] a, input logic [31:0] d);
    cf_sel = ctrl; rf_sel = !ctrl; wr_en = 1'b1; addr = a; wdata = d;
    last_cnt = cnt;
    @(negedge clk);
    cf_sel = 0; rf_sel = 0; wr_en = 0;
  endtask

  task automatic rd(input bit ctrl, input logic [11:0] a, input logic [31:0] e, input string tag);
    cf_sel = ctrl; rf_sel = !ctrl; rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    cf_sel = 0; rf_sel = 0; rd_en = 0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (exp_q.size() == 0) begin
        chk("R10 unexpected rvalid", 64'd1, 64'd0);
      end else begin
        chk(tag_q.pop_front(), {32'd0, rdata}, {32'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 64'd1, 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 warn after reset", {63'd0, warn}, 64'd0);
    chk("R1 reset_req after reset", {63'd0, rreq}, 64'd0);
    chk("R10 no rvalid after reset", {63'd0, rvalid}, 64'd0);
    rd(1, 12'h000, 32'h0, "R1 ctrl reads zero");
    rd(1, 12'h008, 32'h0, "R1 period reads zero");
    rd(1, 12'h010, 32'h0, "R1 deadline low zero");
    rd(1, 12'h014, 32'h0, "R1 deadline high zero");
    rd(1, 12'hFCC, IFACE, "R9 ctrl frame iface id");
    rd(1, 12'hFD0, IDENT, "R9 ctrl frame ident");
    rd(0, 12'hFCC, IFACE, "R9 refresh frame iface id");
    rd(0, 12'hFD0, IDENT, "R9 refresh frame ident");
    rd(0, 12'h000, 32'h0, "R10 refresh reg reads zero");
    rd(1, 12'h100, 32'h0, "R10 unmapped reads zero");
    wr(1, 12'hFCC, 32'hFFFF_FFFF);
    rd(1, 12'hFCC, IFACE, "R9 id write ignored");

    // Period 10, enable, timing of both stages
    wr(1, 12'h008, 32'd10);
    rd(1, 12'h008, 32'd10, "R8 period readback");
    wr(1, 12'h000, 32'h1);
    c0 = last_cnt;
    chk("R3 warn low after enable", {63'd0, warn}, 64'd0);
    rd(1, 12'h010, c0[31:0] + 32'd10, "R3 deadline loaded on ctrl write");
    step(8);
    chk("R4 warn low at P-1", {63'd0, warn}, 64'd0);
    step(1);
    chk("R4 warn high at P", {63'd0, warn}, 64'd1);
    step(9);
    chk("R5 reset_req low at 2P-1", {63'd0, rreq}, 64'd0);
    step(1);
    chk("R5 reset_req high at 2P", {63'd0, rreq}, 64'd1);
    rd(1, 12'h000, 32'h7, "R3 status bits");
    rd(1, 12'h010, c0[31:0] + 32'd20, "R4 deadline reloaded");

    // Refresh frame kick with arbitrary data
    wr(0, 12'h000, 32'hDEAD_BEEF);
    chk("R2 warn cleared by refresh", {63'd0, warn}, 64'd0);
    chk("R2 reset_req cleared by refresh", {63'd0, rreq}, 64'd0);
    step(9);
    chk("R2 warn low before P after refresh", {63'd0, warn}, 64'd0);
    step(1);
    chk("R2 warn high at P after refresh", {63'd0, warn}, 64'd1);
    for (int i = 0; i < 6; i++) begin
      wr(0, 12'h000, 32'(i));
      step(5);
      chk("R2 periodic refresh keeps warn low", {63'd0, warn}, 64'd0);
    end

    // Status bits read-only; disabling
    wr(1, 12'h000, 32'h6);
    rd(1, 12'h000, 32'h0, "R3 status bits read-only");
    step(30);
    chk("R6 warn stays low disabled", {63'd0, warn}, 64'd0);
    chk("R6 reset_req stays low disabled", {63'd0, rreq}, 64'd0);

    // Zero period
    wr(1, 12'h008, 32'd0);
    wr(1, 12'h000, 32'h1);
    chk("R7 warn low on enable edge", {63'd0, warn}, 64'd0);
    step(1);
    chk("R7 warn next edge", {63'd0, warn}, 64'd1);
    chk("R7 reset_req not yet", {63'd0, rreq}, 64'd0);
    step(1);
    chk("R7 reset_req edge after", {63'd0, rreq}, 64'd1);

    // Absolute deadline written directly
    wr(1, 12'h008, 32'd100);
    wr(1, 12'h000, 32'h1);
    wr(1, 12'h010, cnt[31:0] + 32'd5);
    c0 = last_cnt;
    rd(1, 12'h010, c0[31:0] + 32'd5, "R8 deadline readback");
    step(3);
    chk("R8 warn low before deadline", {63'd0, warn}, 64'd0);
    step(1);
    chk("R8 warn high at deadline", {63'd0, warn}, 64'd1);

    step(3);
    chk("R10 scoreboard drained", 64'(exp_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule